// File: doc/BRIEF.md
# ARINC 429 Receive Word Acceptance Filter

This block sits between a serial receiver front end and the word storage of an ARINC 429 receive channel. Each time the front end presents a complete 32-bit word with a one-cycle valid strobe, the block can replace the parity bit with a pass/fail flag. It then decides whether the word is kept. The first gate is an optional check of the two source/destination bits against programmed values. Words that pass this gate are matched against three programmable priority labels and against a 256-entry label-enable bitmap.

A word whose label matches a priority value is captured into that value's 24-bit mailbox. Only bits 9 to 32 are kept, because the label is implied by the match value. A word whose label has its bitmap entry set is presented on a one-cycle FIFO write port. The two outcomes are independent, so a word can take one path, both paths or neither. Control bits and bitmap entries are written one per cycle. The three match values load as a byte sequence and can be read back at all times. Each mailbox has a data-available flag, driven as an output, which clears when the host reads that mailbox.

Word bit n of the ARINC numbering is `in_word[n-1]`. The label is therefore `in_word[7:0]`, exactly as received, with no bit reversal.

Top module: `a429_word_filter`

## Requirements
- R1: With parity checking on (`ctl_wdata[0]`=1), the stored word has bit 32 (`[31]`) set to 0 when `in_word` holds an odd number of ones and to 1 when it holds an even number. Bits 1 to 31 are unchanged.
- R2: With parity checking off, all 32 bits are stored unchanged.
- R3: With the S/D check on (`ctl_wdata[1]`=1), a word is accepted only if `in_word[8]` equals `ctl_wdata[2]` and `in_word[9]` equals `ctl_wdata[3]`. A rejected word produces no FIFO write and no mailbox capture.
- R4: With the S/D check off, every word goes on to label matching.
- R5: With priority capture on (`ctl_wdata[4]`=1), an accepted word whose label `in_word[7:0]` equals match value k is captured in mailbox k. When several match values are equal, every matching mailbox captures the word. With priority capture off, no mailbox changes.
- R6: A mailbox holds bits 9 to 32 of the processed word. `mb_data` shows mailbox 1, 2 or 3 for `mb_sel` 1, 2 or 3, and shows zero for `mb_sel` 0.
- R7: `fifo_we` is high for one cycle, in the cycle after `in_vld`, exactly when the word is accepted and the bitmap entry indexed by its label (written with `lbl_we`/`lbl_idx`/`lbl_bit`) is 1. `fifo_word` then carries the processed word, whether or not a mailbox also captured it.
- R8: Match bytes loaded with `mv_we` go to match value 3, then 2, then 1, in that order, and the sequence then wraps. A byte written with `mv_first` set always goes to match value 3 and restarts the sequence. The values are visible on `match_val1..3`.
- R9: `mb_full[k-1]` sets when mailbox k captures a word. It clears on a cycle with `mb_rd` and `mb_sel`=k. A capture in the same cycle as that read leaves the flag set.
- R10: After reset, all flags, mailboxes, match values, control bits and bitmap entries are zero, and `fifo_we` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Write strobe for the control bits |
| ctl_wdata | input | 5 | {pl_on, sd10, sd9, sd_on, par_on} |
| lbl_we | input | 1 | Write strobe for one bitmap entry |
| lbl_idx | input | 8 | Bitmap entry index (label value) |
| lbl_bit | input | 1 | Bitmap entry value |
| mv_we | input | 1 | Match byte write strobe |
| mv_first | input | 1 | Marks the first byte of a match load sequence |
| mv_byte | input | 8 | Match byte |
| match_val1 | output | 8 | Priority match value 1 |
| match_val2 | output | 8 | Priority match value 2 |
| match_val3 | output | 8 | Priority match value 3 |
| in_vld | input | 1 | Received word strobe |
| in_word | input | 32 | Received word, bit 1 at [0] |
| fifo_we | output | 1 | FIFO write strobe |
| fifo_word | output | 32 | Word to store in the FIFO |
| mb_rd | input | 1 | Mailbox read strobe |
| mb_sel | input | 2 | Mailbox select, 1 to 3 |
| mb_data | output | 24 | Selected mailbox contents |
| mb_full | output | 3 | Mailbox data-available flags |

## Verification
Random words are sent under random control settings. Half of their labels are drawn from the programmed match values, so capture, FIFO-only, both and neither outcomes all occur in volume, together with matched and mismatched S/D bits and both parity parities. Directed words separate the odd and even parity cases and the S/D rejection of a word that would otherwise be captured. Further directed cases cover three equal match values (all mailboxes capture), a read that meets a capture of the same mailbox in one cycle (the flag stays set), and a load sequence restarted by `mv_first` partway through (the byte order is checked).

// File: rtl/a429_word_filter.sv
module a429_word_filter #(
  parameter int WORD_W = 32,
  parameter int LBL_W  = 8,
  parameter int NMB    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic [4:0]        ctl_wdata,
  input  logic              lbl_we,
  input  logic [LBL_W-1:0]  lbl_idx,
  input  logic              lbl_bit,
  input  logic              mv_we,
  input  logic              mv_first,
  input  logic [LBL_W-1:0]  mv_byte,
  output logic [LBL_W-1:0]  match_val1,
  output logic [LBL_W-1:0]  match_val2,
  output logic [LBL_W-1:0]  match_val3,
  input  logic              in_vld,
  input  logic [WORD_W-1:0] in_word,
  output logic              fifo_we,
  output logic [WORD_W-1:0] fifo_word,
  input  logic              mb_rd,
  input  logic [1:0]        mb_sel,
  output logic [WORD_W-LBL_W-1:0] mb_data,
  output logic [NMB-1:0]    mb_full
);
  localparam int MB_W  = WORD_W - LBL_W;
  localparam int MAP_N = 1 << LBL_W;

  logic par_on, sd_on, sd9, sd10, pl_on;
  logic [MAP_N-1:0] lbl_map;
  logic [LBL_W-1:0] mval [NMB];
  logic [MB_W-1:0]  mbox [NMB];
  logic [1:0] ld_ptr;
  logic [NMB-1:0] hit, rd_clr;

  wire [LBL_W-1:0]  lab   = in_word[LBL_W-1:0];
  wire [WORD_W-1:0] pword = par_on ? {~^in_word, in_word[WORD_W-2:0]} : in_word;
  wire sd_ok   = !sd_on || (in_word[8] == sd9 && in_word[9] == sd10);
  wire to_fifo = in_vld && sd_ok && lbl_map[lab];
  wire [1:0] ld_cur = mv_first ? 2'd0 : ld_ptr;

  for (genvar i = 0; i < NMB; i++) begin : g_mb
    assign hit[i]    = in_vld && sd_ok && pl_on && (lab == mval[i]);
    assign rd_clr[i] = mb_rd && (mb_sel == 2'(i + 1));
    always_ff @(posedge clk) begin
      if (!rst_n)      mbox[i] <= '0;
      else if (hit[i]) mbox[i] <= pword[WORD_W-1:LBL_W];
    end
  end

  assign match_val1 = mval[0];
  assign match_val2 = mval[1];
  assign match_val3 = mval[2];

  always_comb begin
    case (mb_sel)
      2'd1:    mb_data = mbox[0];
      2'd2:    mb_data = mbox[1];
      2'd3:    mb_data = mbox[2];
      default: mb_data = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {pl_on, sd10, sd9, sd_on, par_on} <= '0;
      lbl_map <= '0;
      for (int i = 0; i < NMB; i++) mval[i] <= '0;
      ld_ptr    <= '0;
      fifo_we   <= 1'b0;
      fifo_word <= '0;
      mb_full   <= '0;
    end else begin
      if (ctl_we) {pl_on, sd10, sd9, sd_on, par_on} <= ctl_wdata;
      if (lbl_we) lbl_map[lbl_idx] <= lbl_bit;
      if (mv_we) begin
        mval[2'd2 - ld_cur] <= mv_byte;
        ld_ptr <= (ld_cur == 2'd2) ? 2'd0 : ld_cur + 2'd1;
      end
      fifo_we <= to_fifo;
      if (to_fifo) fifo_word <= pword;
      mb_full <= (mb_full & ~rd_clr) | hit;
    end
  end

  // R7
  fifo_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_we |-> $past(in_vld));

  // R1
  par_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_we |-> fifo_word[WORD_W-2:0] == $past(in_word[WORD_W-2:0]));

  // R3
  sd_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_we && $past(sd_on)) |-> fifo_word[9:8] == {$past(sd10), $past(sd9)});

  // R9
  flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(mb_full & ~$past(mb_full))) |-> $past(in_vld && pl_on));

  // R5
  no_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(pl_on) |-> $stable(mb_full) || ($countones(mb_full) < $countones($past(mb_full))));
endmodule

// File: tb/a429_word_filter_bench.sv
module a429_word_filter_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, ctl_we, lbl_we, lbl_bit, mv_we, mv_first, in_vld, fifo_we, mb_rd;
  logic [4:0] ctl_wdata;
  logic [7:0] lbl_idx, mv_byte, match_val1, match_val2, match_val3;
  logic [31:0] in_word, fifo_word;
  logic [1:0] mb_sel;
  logic [23:0] mb_data;
  logic [2:0] mb_full;

  a429_word_filter u_a429_word_filter (.*);

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  bit [4:0]  m_ctl;
  bit [255:0] m_map;
  bit [7:0]  m_mv [1:3];
  bit [23:0] m_mb [1:3];
  bit [2:0]  m_fl;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit [31:0] proc(bit [31:0] w);
    return m_ctl[0] ? {~^w, w[30:0]} : w;
  endfunction

  function automatic bit sd_ok(bit [31:0] w);
    return !m_ctl[1] || (w[8] == m_ctl[2] && w[9] == m_ctl[3]);
  endfunction

  task automatic cfg(bit [4:0] v);
    @(negedge clk); ctl_we = 1; ctl_wdata = v;
    @(negedge clk); ctl_we = 0; m_ctl = v;
  endtask

  task automatic setlbl(bit [7:0] i, bit b);
    @(negedge clk); lbl_we = 1; lbl_idx = i; lbl_bit = b;
    @(negedge clk); lbl_we = 0; m_map[i] = b;
  endtask

  task automatic loadmv(bit [7:0] b3, bit [7:0] b2, bit [7:0] b1);
    @(negedge clk); mv_we = 1; mv_first = 1; mv_byte = b3;
    @(negedge clk); mv_first = 0; mv_byte = b2;
    @(negedge clk); mv_byte = b1;
    @(negedge clk); mv_we = 0;
    m_mv[3] = b3; m_mv[2] = b2; m_mv[1] = b1;
    chk("R8 match_val3", match_val3, b3);
    chk("R8 match_val2", match_val2, b2);
    chk("R8 match_val1", match_val1, b1);
  endtask

  task automatic send(bit [31:0] w, bit rd = 0, bit [1:0] sel = 0);
    bit [31:0] p; bit ok, ef; bit [2:0] cap;
    p = proc(w); ok = sd_ok(w);
    ef = ok && m_map[w[7:0]];
    for (int i = 1; i <= 3; i++) cap[i-1] = ok && m_ctl[4] && (w[7:0] == m_mv[i]);
    @(negedge clk); in_vld = 1; in_word = w; mb_rd = rd; mb_sel = sel;
    @(negedge clk); in_vld = 0; mb_rd = 0;
    if (rd && sel != 0) m_fl[sel-1] = 0;
    for (int i = 1; i <= 3; i++) if (cap[i-1]) begin m_fl[i-1] = 1; m_mb[i] = p[31:8]; end
    chk("R7/R3/R4 fifo_we", fifo_we, ef);
    if (ef) chk("R1/R2 fifo_word", fifo_word, p);
    chk("R5/R9 mb_full", mb_full, m_fl);
  endtask

  task automatic readmb(bit [1:0] sel);
    @(negedge clk); mb_sel = sel; #1;
    chk("R6 mb_data", mb_data, sel == 0 ? 24'h0 : m_mb[sel]);
    mb_rd = 1;
    @(negedge clk); mb_rd = 0;
    if (sel != 0) m_fl[sel-1] = 0;
    chk("R9 mb_full after read", mb_full, m_fl);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    bit [31:0] w;
    void'($urandom(32'h5EED_429));
    rst_n = 0; ctl_we = 0; ctl_wdata = 0; lbl_we = 0; lbl_idx = 0; lbl_bit = 0;
    mv_we = 0; mv_first = 0; mv_byte = 0; in_vld = 0; in_word = 0; mb_rd = 0; mb_sel = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    chk("R10 fifo_we", fifo_we, 0);
    chk("R10 mb_full", mb_full, 0);
    chk("R10 match", {match_val1, match_val2, match_val3}, 0);
    for (int s = 0; s < 4; s++) begin mb_sel = 2'(s); #1; chk("R10 mb_data", mb_data, 0); end

    // R8 order with restart partway through
    @(negedge clk); mv_we = 1; mv_first = 1; mv_byte = 8'hAA;
    @(negedge clk); mv_first = 0; mv_byte = 8'hBB;
    @(negedge clk); mv_first = 1; mv_byte = 8'h31;
    @(negedge clk); mv_first = 0; mv_byte = 8'h32;
    @(negedge clk); mv_byte = 8'h33;
    @(negedge clk); mv_we = 0;
    chk("R8 restart v3", match_val3, 8'h31);
    chk("R8 restart v2", match_val2, 8'h32);
    chk("R8 restart v1", match_val1, 8'h33);
    m_mv[3] = 8'h31; m_mv[2] = 8'h32; m_mv[1] = 8'h33;

    // R1 parity: odd ones -> bit32 = 0, even -> 1
    cfg(5'b00001);
    setlbl(8'h55, 1);
    send(32'h8000_0155);  // 6 ones, even
    chk("R1 even fail bit", fifo_word[31], 1'b1);
    send(32'h0000_0155);  // 5 ones, odd
    chk("R1 odd pass bit", fifo_word[31], 1'b0);
    // R2 disabled
    cfg(5'b00000);
    send(32'h0000_0155);
    chk("R2 passthrough", fifo_word, 32'h0000_0155);

    // R3 S/D reject of a capturable word (sd9=1, sd10=0)
    cfg(5'b10110);
    setlbl(8'h33, 1);
    send(32'h1234_5233);  // bits9,10 = 0,1 -> reject
    chk("R3 reject no flag", mb_full, 3'b000);
    send(32'h1234_5133);  // 1,0 -> accept
    chk("R3 accept mb1", mb_full, 3'b001);
    // R4 disabled passes
    cfg(5'b10000);
    send(32'h0000_0331);
    chk("R4 accept mb3", mb_full[2], 1'b1);

    // R9 capture wins over simultaneous read
    send(32'hCAFE_0133, 1, 2'd1);
    chk("R9 capture beats read", mb_full[0], 1'b1);
    readmb(1); readmb(2); readmb(3); readmb(0);

    // R5 duplicate match values, all capture
    loadmv(8'h77, 8'h77, 8'h77);
    send(32'h0BAD_F077);
    chk("R5 dup capture", mb_full, 3'b111);
    readmb(1); readmb(2); readmb(3);
    // R5 capture off
    cfg(5'b00000);
    send(32'h0BAD_F077);
    chk("R5 off no capture", mb_full, 3'b000);

    // constrained random
    loadmv(8'h12, 8'h9C, 8'hE4);
    for (int n = 0; n < 4000; n++) begin
      int a; a = $urandom % 16;
      if (a == 0) cfg(5'($urandom));
      else if (a < 3) setlbl(8'($urandom), 1'($urandom));
      else if (a == 3) readmb(2'($urandom));
      else if (a == 4 && ($urandom % 8) == 0) loadmv(8'($urandom), 8'($urandom), 8'($urandom % 4));
      else begin
        w = $urandom;
        if ($urandom % 2) w[7:0] = m_mv[1 + ($urandom % 3)];
        send(w, 1'($urandom % 4 == 0), 2'($urandom));
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule